// File: doc/BRIEF.md
# Test Access Port with User Scan Ports

This block is a test access port controller with the usual serial pins: test clock, mode select, serial data in and serial data out. It steps the sixteen-state controller on the rising edge of the test clock, holds a six-bit instruction register, a one-bit bypass register and a fixed 32-bit identification register. Up to four user instructions are decoded. Each one gets a port towards user logic in the fabric.

Each user port has two outputs of its own: a select flag and a gated data clock. The reset, capture, shift, update and run-test indicators, and the serial data input, are broadcast to all ports. User logic clocks its own scan register on the gated data clock. It returns one serial bit per port, and the controller steers the bit of the selected port onto the serial output. The select flags, the indicators and the serial output all change on the falling edge of the test clock, so user logic and the external tester sample them on the rising edge.

Top module: `jtag_user_tap`

## Requirements
- R1: The controller follows the standard sixteen-state transition graph on rising test-clock edges. Five consecutive rising edges with mode select high reach Test-Logic-Reset from any state, and mode select held high keeps it there.
- R2: While the active-low global reset `rst_n` is low, the following hold at once: the reset indicator is high, every select flag is low, every gated data clock is high and the serial output is disabled. The instruction register holds the identification code 0x09, so a data scan right after reset shifts out the identification value.
- R3: In Capture-IR the six-bit instruction shift register loads 6'b000001. In Shift-IR it shifts toward bit 0, with new data entering at bit 5. The active instruction changes only on a falling edge in Update-IR, or to 0x09 on a falling edge in Test-Logic-Reset.
- R4: User port k (k = 0..3) is selected by instruction code 0x02, 0x03, 0x22 or 0x23 respectively. Its select flag changes only on the falling edge in Update-IR, and it is cleared in Test-Logic-Reset.
- R5: The reset indicator is high while the controller is in Test-Logic-Reset and is released on the first falling edge after the controller leaves that state.
- R6: The capture, shift and update indicators are high in Capture-DR, Shift-DR and Update-DR respectively. Each changes on a falling edge, and at most one indicator is high at a time.
- R7: The run-test indicator is high while the controller is in Run-Test/Idle, and changes on a falling edge.
- R8: A port's gated data clock equals the test clock while that port is selected and the controller is in Capture-DR or Shift-DR. At all other times it is held high.
- R9: The serial data input is passed straight through to the user ports with no register.
- R10: The serial output is driven and enabled on the falling edge. In Shift-IR it carries instruction register bit 0. In Shift-DR it carries the selected data register's bit 0 (or the user port's returned bit). In every other state the output is 0 with the enable low.
- R11: Instruction 6'b111111, and any code that is not a user code or 0x09, selects the one-bit bypass register. The bypass register captures 0, so a data scan returns a 0 followed by the input delayed by one bit.
- R12: Instruction 0x09 selects a 32-bit register. It captures the parameter IDCODE_VALUE in Capture-DR and shifts it out least significant bit first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Global reset, active low, asynchronous |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, 0 when not enabled |
| tdo_en | output | 1 | Output enable for tdo (high in Shift-IR and Shift-DR) |
| usr_tdi | output | 1 | Serial data in, passed through to user logic |
| usr_reset | output | 1 | High in Test-Logic-Reset or global reset |
| usr_capture | output | 1 | High in Capture-DR |
| usr_shift | output | 1 | High in Shift-DR |
| usr_update | output | 1 | High in Update-DR |
| usr_runtest | output | 1 | High in Run-Test/Idle |
| usr_sel | output | NUM_USER | Per-port select flag |
| usr_drck | output | NUM_USER | Per-port gated data clock, idles high |
| usr_tdo | input | NUM_USER | Per-port serial return bit from user logic |

## Verification
A random walk of mode-select and data values drives the controller through every state and through arbitrary instruction loads. After each falling edge the indicators, the select flags, the gated clocks and the output enable are compared with a state model held in the bench. Directed scans then load each user code and shift a pattern through a user register modelled in the bench. The pattern must come back behind that register's captured value, which separates a correct port selection and gated clock from a wrong one. Bypass scans, both with all ones and with an unassigned code, show the one-bit delay. Identification scans show the 32-bit captured constant. An asynchronous reset in the middle of the walk, and five-ones recoveries, exercise the reset paths.

// File: rtl/jtag_user_pkg.sv
`timescale 1ns/1ps
package jtag_user_pkg;

    localparam int IR_W     = 6;
    localparam int MAX_USER = 4;
    localparam int ID_W     = 32;

    typedef enum logic [3:0] {
        ST_RESET, ST_IDLE,
        ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_e;

    localparam logic [IR_W-1:0] IR_IDCODE  = 6'h09;
    localparam logic [IR_W-1:0] IR_BYPASS  = '1;
    localparam logic [IR_W-1:0] IR_CAP_PAT = 6'b000001;

    function automatic logic [IR_W-1:0] user_code(input int idx);
        case (idx)
            0:       return 6'h02;
            1:       return 6'h03;
            2:       return 6'h22;
            default: return 6'h23;
        endcase
    endfunction

    function automatic tap_state_e tap_next(input tap_state_e s, input logic tms);
        case (s)
            ST_RESET:  return tms ? ST_RESET  : ST_IDLE;
            ST_IDLE:   return tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: return tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: return tms ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  return tms ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: return tms ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: return tms ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: return tms ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: return tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: return tms ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: return tms ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  return tms ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: return tms ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: return tms ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: return tms ? ST_UPD_IR : ST_SH_IR;
            default:   return tms ? ST_SEL_DR : ST_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/tap_fsm.sv
`timescale 1ns/1ps
module tap_fsm
    import jtag_user_pkg::*;
(
    input  logic       tck,
    input  logic       rst_n,
    input  logic       tms,
    output tap_state_e state_q,
    output tap_state_e state_d,
    output logic       rst_flag,
    output logic       cap_flag,
    output logic       sh_flag,
    output logic       upd_flag,
    output logic       idle_flag
);

    typedef struct packed {
        logic rst;
        logic cap;
        logic sh;
        logic upd;
        logic idle;
    } flags_t;

    flags_t flags_d, flags_q;

    // rising edge: state advance
    always_comb begin
        state_d = tap_next(state_q, tms);
    end

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RESET;
        else        state_q <= state_d;
    end

    // falling edge: indicators for user logic
    always_comb begin
        flags_d      = '0;
        flags_d.rst  = (state_q == ST_RESET);
        flags_d.cap  = (state_q == ST_CAP_DR);
        flags_d.sh   = (state_q == ST_SH_DR);
        flags_d.upd  = (state_q == ST_UPD_DR);
        flags_d.idle = (state_q == ST_IDLE);
    end

    always_ff @(negedge tck or negedge rst_n) begin
        if (!rst_n) flags_q <= '{rst: 1'b1, default: 1'b0};
        else        flags_q <= flags_d;
    end

    assign rst_flag  = flags_q.rst;
    assign cap_flag  = flags_q.cap;
    assign sh_flag   = flags_q.sh;
    assign upd_flag  = flags_q.upd;
    assign idle_flag = flags_q.idle;

    // checker-side count of consecutive high mode-select edges
    logic [2:0] ones_q;
    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n)            ones_q <= '0;
        else if (!tms)         ones_q <= '0;
        else if (ones_q < 3'd5) ones_q <= ones_q + 3'd1;
    end

    AST_TMS_RESET: assert property (@(posedge tck) disable iff (!rst_n)
        (ones_q >= 3'd4 && tms) |=> (state_q == ST_RESET)); // R1
    AST_RESET_HOLD: assert property (@(posedge tck) disable iff (!rst_n)
        (state_q == ST_RESET && tms) |=> (state_q == ST_RESET)); // R1
    AST_RESET_FLAG: assert property (@(negedge tck) disable iff (!rst_n)
        (state_q == ST_RESET) |=> rst_flag); // R5
    AST_RESET_DROP: assert property (@(negedge tck) disable iff (!rst_n)
        (state_q != ST_RESET) |=> !rst_flag); // R5
    AST_CAP_FLAG: assert property (@(negedge tck) disable iff (!rst_n)
        (state_q == ST_CAP_DR) |=> cap_flag); // R6
    AST_FLAG_ONEHOT: assert property (@(negedge tck) disable iff (!rst_n)
        $onehot0({cap_flag, sh_flag, upd_flag})); // R6
    AST_IDLE_FLAG: assert property (@(negedge tck) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> idle_flag); // R7

endmodule

// File: rtl/tap_ir.sv
`timescale 1ns/1ps
module tap_ir
    import jtag_user_pkg::*;
(
    input  logic            tck,
    input  logic            rst_n,
    input  logic            tdi,
    input  tap_state_e      state_q,
    output logic [IR_W-1:0] ir_sr_q,
    output logic [IR_W-1:0] ir_q
);

    logic [IR_W-1:0] ir_sr_d, ir_d;

    // rising edge: capture and shift
    always_comb begin
        ir_sr_d = ir_sr_q;
        if (state_q == ST_CAP_IR)     ir_sr_d = IR_CAP_PAT;
        else if (state_q == ST_SH_IR) ir_sr_d = {tdi, ir_sr_q[IR_W-1:1]};
    end

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) ir_sr_q <= '0;
        else        ir_sr_q <= ir_sr_d;
    end

    // falling edge: active instruction
    always_comb begin
        ir_d = ir_q;
        if (state_q == ST_RESET)       ir_d = IR_IDCODE;
        else if (state_q == ST_UPD_IR) ir_d = ir_sr_q;
    end

    always_ff @(negedge tck or negedge rst_n) begin
        if (!rst_n) ir_q <= IR_IDCODE;
        else        ir_q <= ir_d;
    end

    AST_IR_CAPTURE: assert property (@(posedge tck) disable iff (!rst_n)
        (state_q == ST_CAP_IR) |=> (ir_sr_q == IR_CAP_PAT)); // R3
    AST_IR_HOLD: assert property (@(negedge tck) disable iff (!rst_n)
        (state_q != ST_UPD_IR && state_q != ST_RESET) |=> $stable(ir_q)); // R3

endmodule

// File: rtl/tap_port.sv
`timescale 1ns/1ps
module tap_port
    import jtag_user_pkg::*;
#(
    parameter logic [IR_W-1:0] CODE = 6'h02
) (
    input  logic            tck,
    input  logic            rst_n,
    input  tap_state_e      state_q,
    input  tap_state_e      state_d,
    input  logic [IR_W-1:0] ir_sr_q,
    input  logic [IR_W-1:0] ir_q,
    output logic            sel_o,
    output logic            drck_o
);

    typedef struct packed {
        logic sel;
    } neg_t;

    typedef struct packed {
        logic en;
    } pos_t;

    neg_t neg_d, neg_q;
    pos_t pos_d, pos_q;

    // falling edge: select follows the instruction being updated
    always_comb begin
        neg_d = neg_q;
        if (state_q == ST_RESET)       neg_d.sel = 1'b0;
        else if (state_q == ST_UPD_IR) neg_d.sel = (ir_sr_q == CODE);
    end

    always_ff @(negedge tck or negedge rst_n) begin
        if (!rst_n) neg_q <= '0;
        else        neg_q <= neg_d;
    end

    // rising edge: clock gate changes only while the test clock is high
    always_comb begin
        pos_d.en = neg_q.sel && (state_d == ST_CAP_DR || state_d == ST_SH_DR);
    end

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end

    assign sel_o  = neg_q.sel;
    assign drck_o = tck | ~pos_q.en;

    AST_SEL_MATCH: assert property (@(posedge tck) disable iff (!rst_n)
        sel_o == (ir_q == CODE)); // R4
    AST_DRCK_IDLE: assert property (@(posedge tck) disable iff (!rst_n)
        !(sel_o && (state_q == ST_CAP_DR || state_q == ST_SH_DR)) |-> drck_o); // R8
    AST_DRCK_RUN: assert property (@(posedge tck) disable iff (!rst_n)
        (sel_o && (state_q == ST_CAP_DR || state_q == ST_SH_DR)) |-> !drck_o); // R8

endmodule

// File: rtl/tap_dr.sv
`timescale 1ns/1ps
module tap_dr
    import jtag_user_pkg::*;
#(
    parameter int              NUM_USER     = 4,
    parameter logic [ID_W-1:0] IDCODE_VALUE = 32'h1A5C_E093
) (
    input  logic                tck,
    input  logic                rst_n,
    input  logic                tdi,
    input  tap_state_e          state_q,
    input  logic [IR_W-1:0]     ir_q,
    input  logic [IR_W-1:0]     ir_sr_q,
    input  logic [NUM_USER-1:0] usr_tdo,
    output logic                tdo_o,
    output logic                tdo_en_o
);

    typedef struct packed {
        logic            byp;
        logic [ID_W-1:0] id;
    } sreg_t;

    typedef struct packed {
        logic tdo;
        logic en;
    } out_t;

    sreg_t sreg_d, sreg_q;
    out_t  out_d, out_q;

    logic [NUM_USER-1:0] user_hit;
    logic                is_id;
    logic                dr_bit;

    // instruction decode
    always_comb begin
        for (int i = 0; i < NUM_USER; i++) begin
            user_hit[i] = (ir_q == user_code(i));
        end
        is_id = (ir_q == IR_IDCODE);
        if (|user_hit)  dr_bit = |(user_hit & usr_tdo);
        else if (is_id) dr_bit = sreg_q.id[0];
        else            dr_bit = sreg_q.byp;
    end

    // rising edge: internal data registers
    always_comb begin
        sreg_d = sreg_q;
        if (state_q == ST_CAP_DR) begin
            sreg_d.byp = 1'b0;
            if (is_id) sreg_d.id = IDCODE_VALUE;
        end else if (state_q == ST_SH_DR) begin
            sreg_d.byp = tdi;
            if (is_id) sreg_d.id = {tdi, sreg_q.id[ID_W-1:1]};
        end
    end

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) sreg_q <= '0;
        else        sreg_q <= sreg_d;
    end

    // falling edge: serial output
    always_comb begin
        out_d = '0;
        if (state_q == ST_SH_IR) begin
            out_d.tdo = ir_sr_q[0];
            out_d.en  = 1'b1;
        end else if (state_q == ST_SH_DR) begin
            out_d.tdo = dr_bit;
            out_d.en  = 1'b1;
        end
    end

    always_ff @(negedge tck or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign tdo_o    = out_q.tdo;
    assign tdo_en_o = out_q.en;

    AST_BYP_CAPTURE: assert property (@(posedge tck) disable iff (!rst_n)
        (state_q == ST_CAP_DR) |=> !sreg_q.byp); // R11
    AST_ID_CAPTURE: assert property (@(posedge tck) disable iff (!rst_n)
        (state_q == ST_CAP_DR && is_id) |=> (sreg_q.id == IDCODE_VALUE)); // R12
    AST_TDO_QUIET: assert property (@(negedge tck) disable iff (!rst_n)
        !tdo_en_o |-> !tdo_o); // R10

endmodule

// File: rtl/jtag_user_tap.sv
`timescale 1ns/1ps
module jtag_user_tap
    import jtag_user_pkg::*;
#(
    parameter int              NUM_USER     = 4,
    parameter logic [ID_W-1:0] IDCODE_VALUE = 32'h1A5C_E093
) (
    input  logic                tck,
    input  logic                rst_n,
    input  logic                tms,
    input  logic                tdi,
    output logic                tdo,
    output logic                tdo_en,
    output logic                usr_tdi,
    output logic                usr_reset,
    output logic                usr_capture,
    output logic                usr_shift,
    output logic                usr_update,
    output logic                usr_runtest,
    output logic [NUM_USER-1:0] usr_sel,
    output logic [NUM_USER-1:0] usr_drck,
    input  logic [NUM_USER-1:0] usr_tdo
);

    tap_state_e      state_q, state_d;
    logic [IR_W-1:0] ir_sr_q, ir_q;

    tap_fsm u_fsm (
        .tck       (tck),
        .rst_n     (rst_n),
        .tms       (tms),
        .state_q   (state_q),
        .state_d   (state_d),
        .rst_flag  (usr_reset),
        .cap_flag  (usr_capture),
        .sh_flag   (usr_shift),
        .upd_flag  (usr_update),
        .idle_flag (usr_runtest)
    );

    tap_ir u_ir (
        .tck     (tck),
        .rst_n   (rst_n),
        .tdi     (tdi),
        .state_q (state_q),
        .ir_sr_q (ir_sr_q),
        .ir_q    (ir_q)
    );

    for (genvar g = 0; g < NUM_USER; g++) begin : g_port
        tap_port #(
            .CODE (user_code(g))
        ) u_port (
            .tck     (tck),
            .rst_n   (rst_n),
            .state_q (state_q),
            .state_d (state_d),
            .ir_sr_q (ir_sr_q),
            .ir_q    (ir_q),
            .sel_o   (usr_sel[g]),
            .drck_o  (usr_drck[g])
        );
    end

    tap_dr #(
        .NUM_USER     (NUM_USER),
        .IDCODE_VALUE (IDCODE_VALUE)
    ) u_dr (
        .tck      (tck),
        .rst_n    (rst_n),
        .tdi      (tdi),
        .state_q  (state_q),
        .ir_q     (ir_q),
        .ir_sr_q  (ir_sr_q),
        .usr_tdo  (usr_tdo),
        .tdo_o    (tdo),
        .tdo_en_o (tdo_en)
    );

    assign usr_tdi = tdi;

endmodule

// File: tb/jtag_user_tap_bench.sv
`timescale 1ns/1ps
module jtag_user_tap_bench;

    localparam int          NU  = 4;
    localparam logic [31:0] IDV = 32'h1A5C_E093;

    // bench-side state numbering
    localparam int S_TLR = 0,  S_RTI = 1,  S_SDR = 2,  S_CDR = 3,  S_SHD = 4,  S_E1D = 5;
    localparam int S_PDR = 6,  S_E2D = 7,  S_UDR = 8,  S_SIR = 9,  S_CIR = 10, S_SHI = 11;
    localparam int S_E1I = 12, S_PIR = 13, S_E2I = 14, S_UIR = 15;

    logic tck = 1'b0;
    logic rst_n, tms, tdi;
    logic tdo, tdo_en, usr_tdi, usr_reset, usr_capture, usr_shift, usr_update, usr_runtest;
    logic [NU-1:0] usr_sel, usr_drck, usr_tdo;

    int n_chk = 0;
    int n_bad = 0;

    int         ms;
    logic [5:0] m_ir, m_irsr;

    always #2 tck = ~tck;

    jtag_user_tap #(.NUM_USER(NU), .IDCODE_VALUE(IDV)) u_jtag_user_tap (
        .tck(tck), .rst_n(rst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en),
        .usr_tdi(usr_tdi), .usr_reset(usr_reset), .usr_capture(usr_capture),
        .usr_shift(usr_shift), .usr_update(usr_update), .usr_runtest(usr_runtest),
        .usr_sel(usr_sel), .usr_drck(usr_drck), .usr_tdo(usr_tdo)
    );

    function automatic logic [7:0] kval(input int g);
        return 8'hC5 ^ 8'(g * 17);
    endfunction

    function automatic logic [5:0] ucode(input int g);
        case (g)
            0: return 6'h02;
            1: return 6'h03;
            2: return 6'h22;
            default: return 6'h23;
        endcase
    endfunction

    function automatic int nxt(input int s, input bit t);
        case (s)
            S_TLR: return t ? S_TLR : S_RTI;
            S_RTI: return t ? S_SDR : S_RTI;
            S_SDR: return t ? S_SIR : S_CDR;
            S_CDR: return t ? S_E1D : S_SHD;
            S_SHD: return t ? S_E1D : S_SHD;
            S_E1D: return t ? S_UDR : S_PDR;
            S_PDR: return t ? S_E2D : S_PDR;
            S_E2D: return t ? S_UDR : S_SHD;
            S_UDR: return t ? S_SDR : S_RTI;
            S_SIR: return t ? S_TLR : S_CIR;
            S_CIR: return t ? S_E1I : S_SHI;
            S_SHI: return t ? S_E1I : S_SHI;
            S_E1I: return t ? S_UIR : S_PIR;
            S_PIR: return t ? S_E2I : S_PIR;
            S_E2I: return t ? S_UIR : S_SHI;
            default: return t ? S_SDR : S_RTI;
        endcase
    endfunction

    // user-side scan registers, one per port
    for (genvar g = 0; g < NU; g++) begin : g_um
        logic [7:0] sr = 8'h00;
        always @(posedge usr_drck[g]) begin
            if (usr_capture)    sr <= kval(g);
            else if (usr_shift) sr <= {usr_tdi, sr[7:1]};
        end
        assign usr_tdo[g] = sr[0];
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // outputs that follow the falling edge, against the model
    task automatic check_outputs();
        chk("R5 reset indicator",   usr_reset,   ms == S_TLR);
        chk("R6 capture indicator", usr_capture, ms == S_CDR);
        chk("R6 shift indicator",   usr_shift,   ms == S_SHD);
        chk("R6 update indicator",  usr_update,  ms == S_UDR);
        chk("R7 run-test indicator", usr_runtest, ms == S_RTI);
        chk("R10 output enable", tdo_en, (ms == S_SHI) || (ms == S_SHD));
        if (ms == S_SHI)      chk("R10 tdo carries IR bit 0", tdo, m_irsr[0]);
        else if (ms != S_SHD) chk("R10 tdo quiet", tdo, 1'b0);
        for (int g = 0; g < NU; g++) begin
            chk("R4 select flag", usr_sel[g], m_ir == ucode(g));
            chk("R8 gated clock low phase", usr_drck[g],
                !((m_ir == ucode(g)) && (ms == S_CDR || ms == S_SHD)));
        end
    endtask

    // one test-clock period; entered just after a falling edge
    task automatic step(input bit t, input bit d);
        tms = t;
        tdi = d;
        #0.2;
        chk("R9 data pass-through", usr_tdi, d);
        @(posedge tck);
        if (ms == S_CIR)      m_irsr = 6'b000001;
        else if (ms == S_SHI) m_irsr = {d, m_irsr[5:1]};
        ms = nxt(ms, t);
        #0.5;
        chk("R8 gated clock high phase", usr_drck, {NU{1'b1}});
        @(negedge tck);
        if (ms == S_TLR)      m_ir = 6'h09;
        else if (ms == S_UIR) m_ir = m_irsr;
        #0.5;
        check_outputs();
    endtask

    task automatic shift_bits(input logic [63:0] din, input int n, output logic [63:0] dout);
        dout = '0;
        for (int i = 0; i < n; i++) begin
            dout[i] = tdo;
            step(i == n - 1, din[i]);
        end
    endtask

    task automatic go_reset();
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
        step(1'b0, 1'b0);
    endtask

    task automatic load_ir(input logic [5:0] code, output logic [5:0] cap);
        logic [63:0] o;
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        shift_bits({58'd0, code}, 6, o);
        cap = o[5:0];
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
    endtask

    task automatic scan_dr(input logic [63:0] din, input int n, output logic [63:0] dout);
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        shift_bits(din, n, dout);
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
    endtask

    initial begin
        #800000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [5:0]  cap;
        logic [63:0] o;
        logic [15:0] pat;
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        tms   = 1'b1;
        tdi   = 1'b0;
        ms    = S_TLR;
        m_ir  = 6'h09;
        m_irsr = 6'h00;
        @(negedge tck);
        #0.5;
        // R2: state under global reset
        chk("R2 reset indicator", usr_reset, 1'b1);
        chk("R2 selects clear", usr_sel, '0);
        chk("R2 gated clocks high", usr_drck, {NU{1'b1}});
        chk("R2 output disabled", tdo_en, 1'b0);
        rst_n = 1'b1;
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);

        // R2 / R12: identification selected straight after reset
        scan_dr(64'd0, 32, o);
        chk("R2 IDCODE after reset", o[31:0], IDV);

        // R3: capture pattern, R11: all-ones bypass
        load_ir(6'h3F, cap);
        chk("R3 IR capture pattern", cap, 6'b000001);
        pat = 16'hB39E;
        scan_dr({48'd0, pat}, 16, o);
        chk("R11 bypass delay", o[15:0], {pat[14:0], 1'b0});

        // R4 / R8: every user port with a bench-side register
        for (int g = 0; g < NU; g++) begin
            load_ir(ucode(g), cap);
            chk("R4 select after update", usr_sel, NU'(1) << g);
            pat = 16'(($urandom() & 16'hFFFF));
            scan_dr({48'd0, pat}, 16, o);
            chk("R4 user capture value", o[7:0], kval(g));
            chk("R8 user loop-back", o[15:8], pat[7:0]);
        end

        // R11: unassigned code also bypasses
        load_ir(6'h15, cap);
        chk("R4 no select for unassigned", usr_sel, '0);
        pat = 16'h5A0F;
        scan_dr({48'd0, pat}, 16, o);
        chk("R11 unassigned bypass", o[15:0], {pat[14:0], 1'b0});

        // R12: explicit identification instruction
        load_ir(6'h09, cap);
        scan_dr(64'hFFFF_FFFF, 32, o);
        chk("R12 IDCODE shift", o[31:0], IDV);

        // R1: random walk with five-ones recoveries and one async reset
        for (int i = 0; i < 900; i++) begin
            if (i == 450) begin
                rst_n = 1'b0;
                #0.3;
                chk("R2 async reset indicator", usr_reset, 1'b1);
                chk("R2 async reset selects", usr_sel, '0);
                rst_n = 1'b1;
                ms = S_TLR;
                m_ir = 6'h09;
                m_irsr = 6'h00;
            end
            if (i % 150 == 149) begin
                for (int k = 0; k < 5; k++) step(1'b1, 1'b0);
                chk("R1 five ones reach reset", usr_reset, 1'b1);
                chk("R1 model agrees", ms, S_TLR);
            end else begin
                step(($urandom() % 3) == 0, $urandom() % 2);
            end
        end

        // user port still works after the walk
        go_reset();
        load_ir(ucode(NU - 1), cap);
        chk("R3 capture after walk", cap, 6'b000001);
        scan_dr({48'd0, 16'h0000}, 16, o);
        chk("R4 last port capture", o[7:0], kval(NU - 1));

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule